// File: doc/BRIEF.md
# Disk Controller Command and Interrupt Unit

This unit is the software-facing command front end of a cartridge disk controller. Software sees four 16-bit word registers through a plain read/write port: control/status, bus address, disk address and word count. A write to control/status that leaves the ready bit clear launches the selected function. The unit then either finishes at once (status fetch), or hands the work to a seek engine or a data-transfer engine through start/done handshakes and waits for it to finish. The unit records the current track, head and sector. A completed seek or read raises an interrupt request when software has enabled interrupts.

Memory addresses are 18 bits wide. The low 16 bits live in the bus address register and the top two bits live in the control/status register. When a transfer finishes, the transfer engine returns its end address, and that address is written back across both registers. Function codes other than status, seek and the two read variants are accepted but do nothing.

Top module: `dkc_cmd_unit`

## Requirements
- R1: Registers are reached at byte offsets 0 (control/status), 2 (bus address), 4 (disk address) and 6 (word count). A read returns the word on `bus_rdata` one clock after `bus_rd`. Accesses at odd offsets are ignored.
- R2: Control/status bits 5:4 hold memory address bits 17:16, and the bus address register holds bits 15:0. `xfer_mem_addr` presents the concatenation. When a transfer completes, `xfer_end_addr` is loaded into both registers.
- R3: A control/status write with bit 7 clear, made while the unit is ready, starts the function in bits 3:1. Bit 7 reads 0 while a seek or read is in progress and reads 1 otherwise.
- R4: Function 2 (status) clears the word count register, leaves the unit ready and raises no interrupt.
- R5: Function 3 (seek) pulses `seek_start` for one cycle with the disk address register on `seek_dar`. On `seek_done`, the current track takes `seek_track`, limited to TRACKS-1.
- R6: Functions 6 and 7 (read) load the track from disk address bits 15:7, the head from bit 6 and the sector from bits 5:0, then pulse `xfer_start` for one cycle. `xfer_hdr_check` is 1 for function 6 and 0 for function 7.
- R7: When a seek or read completes and control/status bit 6 (interrupt enable) is set, `irq` pulses for one cycle, one cycle after ready returns, with `irq_level` 4 and `irq_vector` octal 160. With bit 6 clear, no pulse is raised.
- R8: A control/status write that arrives while a seek or read is in progress is ignored entirely.
- R9: Reset clears all registers, the current track, head and sector, and all outputs. Afterwards control/status reads 0x0080.
- R10: Function codes 0, 1, 4 and 5 start nothing, keep the unit ready and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| seek_start | output | 1 | One-cycle seek launch |
| seek_dar | output | 16 | Disk address word for the seek engine |
| seek_done | input | 1 | Seek engine finished |
| seek_track | input | TRK_W+1 | Resulting track from the seek engine |
| xfer_start | output | 1 | One-cycle read launch |
| xfer_hdr_check | output | 1 | 1 when the header must be checked |
| xfer_mem_addr | output | 18 | Memory start address |
| xfer_words | output | 16 | Word count register value |
| xfer_track | output | TRK_W | Current track |
| xfer_head | output | 1 | Current head |
| xfer_sector | output | SEC_W | Current sector |
| xfer_done | input | 1 | Transfer engine finished |
| xfer_end_addr | input | 18 | Memory address after the transfer |
| irq | output | 1 | One-cycle interrupt request |
| irq_vector | output | 9 | Interrupt vector |
| irq_level | output | 3 | Interrupt priority |

## Verification
The hardest case to reach from the ports is a control/status write that lands while a command is still waiting on its engine. Reaching it needs a command that stays busy. The bench starts a seek and deliberately holds back `seek_done`. While the seek is pending, it writes an executing, interrupt-disabling value, then reads control/status to show the old fields and a clear ready bit. It then confirms that the late completion still delivers the interrupt. The track limit is reached by having the modelled seek engine return a track beyond the last cylinder.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int DW       = 16;
  localparam int OFS_W    = 3;
  localparam int AX_W     = 2;
  localparam int MA_W     = DW + AX_W;
  localparam int FN_W     = 3;
  localparam int CSR_FN_LO = 1;
  localparam int CSR_AX_LO = 4;
  localparam int CSR_IE    = 6;
  localparam int CSR_RDY   = 7;

  typedef enum logic [1:0] {
    RI_CSR = 2'd0,
    RI_BAR = 2'd1,
    RI_DAR = 2'd2,
    RI_MPR = 2'd3
  } reg_idx_e;

  localparam logic [FN_W-1:0] FN_STAT = 3'd2;
  localparam logic [FN_W-1:0] FN_SEEK = 3'd3;
  localparam logic [FN_W-1:0] FN_RDH  = 3'd6;
  localparam logic [FN_W-1:0] FN_RDN  = 3'd7;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SEEK = 2'd1,
    SQ_XFER = 2'd2
  } sq_e;

  localparam logic [8:0] IRQ_VEC = 9'o160;
  localparam logic [2:0] IRQ_LVL = 3'd4;
endpackage

// File: rtl/dkc_regs.sv
module dkc_regs
  import dkc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             busy,
  input  logic             bar_ld,
  input  logic [MA_W-1:0]  bar_val,
  output logic             cmd_go,
  output logic [FN_W-1:0]  cmd_fn,
  output logic             ie,
  output logic [MA_W-1:0]  mem_addr,
  output logic [DW-1:0]    dar,
  output logic [DW-1:0]    mpr
);
  logic       aligned;
  logic [1:0] widx;
  logic       wr_csr;
  logic       csr_take;

  assign aligned  = ~addr[0];
  assign widx     = addr[2:1];
  assign wr_csr   = wr_en & aligned & (widx == RI_CSR);
  assign csr_take = wr_csr & ~busy;
  assign cmd_go   = csr_take & ~wdata[CSR_RDY];
  assign cmd_fn   = wdata[CSR_FN_LO +: FN_W];

  logic [FN_W-1:0] fn_q;
  logic [AX_W-1:0] ax_q;
  logic            ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_q <= '0;
      ie_q <= 1'b0;
      ax_q <= '0;
    end else begin
      if (csr_take) begin
        fn_q <= wdata[CSR_FN_LO +: FN_W];
        ie_q <= wdata[CSR_IE];
      end
      if (bar_ld)
        ax_q <= bar_val[MA_W-1 -: AX_W];
      else if (csr_take)
        ax_q <= wdata[CSR_AX_LO +: AX_W];
    end
  end

  assign ie = ie_q;

  // internal loads for the three plain word registers (index 1..3)
  logic [3:1]    ld;
  logic [DW-1:0] ldv [1:3];

  always_comb begin
    ld     = '0;
    ld[1]  = bar_ld;
    ld[3]  = cmd_go && (cmd_fn == FN_STAT);
    ldv[1] = bar_val[DW-1:0];
    ldv[2] = '0;
    ldv[3] = '0;
  end

  for (genvar gi = 1; gi <= 3; gi++) begin : g_wreg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (ld[gi])
        q <= ldv[gi];
      else if (wr_en && aligned && (widx == 2'(gi)))
        q <= wdata;
    end
  end

  assign mem_addr = {ax_q, g_wreg[1].q};
  assign dar      = g_wreg[2].q;
  assign mpr      = g_wreg[3].q;

  logic [DW-1:0] csr_view;
  always_comb begin
    csr_view = '0;
    csr_view[CSR_FN_LO +: FN_W] = fn_q;
    csr_view[CSR_AX_LO +: AX_W] = ax_q;
    csr_view[CSR_IE]            = ie_q;
    csr_view[CSR_RDY]           = ~busy;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en && aligned) begin
      case (widx)
        RI_CSR:  rdata <= csr_view;
        RI_BAR:  rdata <= g_wreg[1].q;
        RI_DAR:  rdata <= g_wreg[2].q;
        default: rdata <= g_wreg[3].q;
      endcase
    end
  end
endmodule

// File: rtl/dkc_seq.sv
module dkc_seq
  import dkc_pkg::*;
#(
  parameter int TRK_W  = 9,
  parameter int TRACKS = 512,
  parameter int SEC_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_go,
  input  logic [FN_W-1:0]  cmd_fn,
  input  logic [DW-1:0]    dar,
  input  logic             seek_done,
  input  logic [TRK_W:0]   seek_track,
  input  logic             xfer_done,
  output logic             busy,
  output logic             seek_start,
  output logic             xfer_start,
  output logic             hdr_check,
  output logic [TRK_W-1:0] cur_track,
  output logic             cur_head,
  output logic [SEC_W-1:0] cur_sector,
  output logic             cmp_pulse,
  output logic             bar_ld
);
  localparam int HEAD_BIT = SEC_W;
  localparam int TRK_LO   = SEC_W + 1;
  localparam logic [TRK_W:0] MAXT = (TRK_W+1)'(TRACKS - 1);

  sq_e  st;
  logic idle;
  logic launch_seek;
  logic launch_rd;
  logic seek_fin;
  logic xfer_fin;
  logic [TRK_W-1:0] trk_lim;

  assign idle        = (st == SQ_IDLE);
  assign launch_seek = idle & cmd_go & (cmd_fn == FN_SEEK);
  assign launch_rd   = idle & cmd_go & ((cmd_fn == FN_RDH) | (cmd_fn == FN_RDN));
  assign seek_fin    = (st == SQ_SEEK) & seek_done;
  assign xfer_fin    = (st == SQ_XFER) & xfer_done;
  assign busy        = ~idle;
  assign bar_ld      = xfer_fin;

  always_comb begin
    if (seek_track > MAXT)
      trk_lim = MAXT[TRK_W-1:0];
    else
      trk_lim = seek_track[TRK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      seek_start <= 1'b0;
      xfer_start <= 1'b0;
      cmp_pulse  <= 1'b0;
      hdr_check  <= 1'b0;
      cur_track  <= '0;
      cur_head   <= 1'b0;
      cur_sector <= '0;
    end else begin
      seek_start <= launch_seek;
      xfer_start <= launch_rd;
      cmp_pulse  <= seek_fin | xfer_fin;
      case (st)
        SQ_IDLE: begin
          if (launch_seek)
            st <= SQ_SEEK;
          else if (launch_rd) begin
            st         <= SQ_XFER;
            cur_sector <= dar[SEC_W-1:0];
            cur_head   <= dar[HEAD_BIT];
            cur_track  <= dar[TRK_LO +: TRK_W];
            hdr_check  <= (cmd_fn == FN_RDH);
          end
        end
        SQ_SEEK: begin
          if (seek_done) begin
            cur_track <= trk_lim;
            st        <= SQ_IDLE;
          end
        end
        SQ_XFER: begin
          if (xfer_done)
            st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dkc_irq.sv
module dkc_irq
  import dkc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmp,
  input  logic       ie,
  output logic       irq,
  output logic [8:0] irq_vector,
  output logic [2:0] irq_level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      irq_vector <= '0;
      irq_level  <= '0;
    end else begin
      irq <= cmp & ie;
      if (cmp & ie) begin
        irq_vector <= IRQ_VEC;
        irq_level  <= IRQ_LVL;
      end
    end
  end
endmodule

// File: rtl/dkc_cmd_unit.sv
module dkc_cmd_unit
  import dkc_pkg::*;
#(
  parameter int TRK_W  = 9,
  parameter int TRACKS = 512,
  parameter int SEC_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  output logic             seek_start,
  output logic [15:0]      seek_dar,
  input  logic             seek_done,
  input  logic [TRK_W:0]   seek_track,
  output logic             xfer_start,
  output logic             xfer_hdr_check,
  output logic [17:0]      xfer_mem_addr,
  output logic [15:0]      xfer_words,
  output logic [TRK_W-1:0] xfer_track,
  output logic             xfer_head,
  output logic [SEC_W-1:0] xfer_sector,
  input  logic             xfer_done,
  input  logic [17:0]      xfer_end_addr,
  output logic             irq,
  output logic [8:0]       irq_vector,
  output logic [2:0]       irq_level
);
  logic            seq_busy;
  logic            cmd_go;
  logic [FN_W-1:0] cmd_fn;
  logic            ie;
  logic            bar_ld;
  logic            cmp_pulse;
  logic [DW-1:0]   dar;

  dkc_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .busy     (seq_busy),
    .bar_ld   (bar_ld),
    .bar_val  (xfer_end_addr),
    .cmd_go   (cmd_go),
    .cmd_fn   (cmd_fn),
    .ie       (ie),
    .mem_addr (xfer_mem_addr),
    .dar      (dar),
    .mpr      (xfer_words)
  );

  dkc_seq #(.TRK_W(TRK_W), .TRACKS(TRACKS), .SEC_W(SEC_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_go     (cmd_go),
    .cmd_fn     (cmd_fn),
    .dar        (dar),
    .seek_done  (seek_done),
    .seek_track (seek_track),
    .xfer_done  (xfer_done),
    .busy       (seq_busy),
    .seek_start (seek_start),
    .xfer_start (xfer_start),
    .hdr_check  (xfer_hdr_check),
    .cur_track  (xfer_track),
    .cur_head   (xfer_head),
    .cur_sector (xfer_sector),
    .cmp_pulse  (cmp_pulse),
    .bar_ld     (bar_ld)
  );

  dkc_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .cmp        (cmp_pulse),
    .ie         (ie),
    .irq        (irq),
    .irq_vector (irq_vector),
    .irq_level  (irq_level)
  );

  assign seek_dar = dar;
endmodule

// File: rtl/dkc_cmd_chk.sv
module dkc_cmd_chk #(
  parameter int TRK_W = 9,
  parameter int SEC_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             seek_start,
  input logic             xfer_start,
  input logic             irq,
  input logic [8:0]       irq_vector,
  input logic [2:0]       irq_level,
  input logic [TRK_W-1:0] cur_track,
  input logic             cur_head,
  input logic [SEC_W-1:0] cur_sector
);
  assert_launch_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (seek_start || xfer_start) |-> busy);

  assert_single_launch_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({seek_start, xfer_start}));

  assert_seek_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    seek_start |=> !seek_start);

  assert_xfer_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_irq_vec_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_vector == 9'o160) && (irq_level == 3'd4));

  assert_irq_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(busy, 2));

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_track == '0) && !cur_head && (cur_sector == '0) && !busy);
endmodule

bind dkc_cmd_unit dkc_cmd_chk #(.TRK_W(TRK_W), .SEC_W(SEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (seq_busy),
  .seek_start (seek_start),
  .xfer_start (xfer_start),
  .irq        (irq),
  .irq_vector (irq_vector),
  .irq_level  (irq_level),
  .cur_track  (xfer_track),
  .cur_head   (xfer_head),
  .cur_sector (xfer_sector)
);

// File: tb/dkc_cmd_unit_tb.sv
module dkc_cmd_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        seek_start, seek_done = 1'b0;
  logic [15:0] seek_dar;
  logic [9:0]  seek_track = '0;
  logic        xfer_start, xfer_hdr_check, xfer_head, xfer_done = 1'b0;
  logic [17:0] xfer_mem_addr, xfer_end_addr = '0;
  logic [15:0] xfer_words;
  logic [8:0]  xfer_track;
  logic [5:0]  xfer_sector;
  logic        irq;
  logic [8:0]  irq_vector;
  logic [2:0]  irq_level;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dkc_cmd_unit u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seek_start(seek_start),
    .seek_dar(seek_dar), .seek_done(seek_done), .seek_track(seek_track),
    .xfer_start(xfer_start), .xfer_hdr_check(xfer_hdr_check),
    .xfer_mem_addr(xfer_mem_addr), .xfer_words(xfer_words), .xfer_track(xfer_track),
    .xfer_head(xfer_head), .xfer_sector(xfer_sector), .xfer_done(xfer_done),
    .xfer_end_addr(xfer_end_addr), .irq(irq), .irq_vector(irq_vector), .irq_level(irq_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(req, 32'(d), 32'(exp));
  endtask

  // watch irq over n cycles and return how often it was high
  task automatic count_irq(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) hits++;
    end
  endtask

  // completion timing: done seen at edge E; irq high for the cycle after E+1
  task automatic expect_irq_after_done(input string req, input logic want);
    check({req, " irq low at done"}, 32'(irq), 0);
    @(negedge clk);
    check({req, " irq pulse"}, 32'(irq), 32'(want));
    if (want) begin
      check({req, " vector"}, 32'(irq_vector), 32'o160);
      check({req, " level"}, 32'(irq_level), 4);
    end
    @(negedge clk);
    check({req, " irq ends"}, 32'(irq), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 track", 32'(xfer_track), 0);
    check("R9 head", 32'(xfer_head), 0);
    check("R9 sector", 32'(xfer_sector), 0);
    check("R9 irq", 32'(irq), 0);
    rd_chk("R9 csr", 3'd0, 16'h0080);
    rd_chk("R9 bar", 3'd2, 16'h0000);
    rd_chk("R9 dar", 3'd4, 16'h0000);
    rd_chk("R9 mpr", 3'd6, 16'h0000);
  endtask

  task automatic t_regs();
    wr(3'd2, 16'h1234);
    wr(3'd4, 16'hABCD);
    wr(3'd6, 16'hFFF0);
    rd_chk("R1 bar", 3'd2, 16'h1234);
    rd_chk("R1 dar", 3'd4, 16'hABCD);
    rd_chk("R1 mpr", 3'd6, 16'hFFF0);
    wr(3'd3, 16'h5555);
    rd_chk("R1 odd write ignored", 3'd2, 16'h1234);
  endtask

  task automatic t_addr();
    wr(3'd0, 16'h00A0);
    rd_chk("R2 csr ext bits", 3'd0, 16'h00A0);
    check("R2 mem addr", 32'(xfer_mem_addr), 32'h21234);
  endtask

  task automatic t_status();
    int h;
    wr(3'd0, 16'h0044);
    check("R4 mpr cleared", 32'(xfer_words), 0);
    count_irq(5, h);
    check("R4 no irq", 32'(h), 0);
    rd_chk("R4 ready stays", 3'd0, 16'h00C4);
  endtask

  task automatic t_seek_ie();
    wr(3'd4, 16'h0384);
    wr(3'd0, 16'h0046);
    check("R5 seek_start", 32'(seek_start), 1);
    check("R5 seek_dar", 32'(seek_dar), 32'h0384);
    @(negedge clk);
    check("R5 seek_start pulse", 32'(seek_start), 0);
    rd_chk("R3 busy clears ready", 3'd0, 16'h0046);
    wr(3'd0, 16'h0000);
    check("R8 no new launch", 32'(seek_start), 0);
    rd_chk("R8 busy csr write ignored", 3'd0, 16'h0046);
    @(negedge clk); seek_done = 1'b1; seek_track = 10'd100;
    @(negedge clk); seek_done = 1'b0;
    check("R5 track loaded", 32'(xfer_track), 100);
    expect_irq_after_done("R7 seek", 1'b1);
    rd_chk("R3 ready back", 3'd0, 16'h00C6);
  endtask

  task automatic t_seek_clamp();
    int h;
    wr(3'd0, 16'h0006);
    @(negedge clk); seek_done = 1'b1; seek_track = 10'd700;
    @(negedge clk); seek_done = 1'b0;
    check("R5 track clamp", 32'(xfer_track), 511);
    count_irq(4, h);
    check("R7 no irq without enable", 32'(h), 0);
  endtask

  task automatic t_read_hdr();
    wr(3'd4, 16'h12CD);
    wr(3'd2, 16'h0400);
    wr(3'd6, 16'hFF00);
    wr(3'd0, 16'h005C);
    check("R6 xfer_start", 32'(xfer_start), 1);
    check("R6 hdr check", 32'(xfer_hdr_check), 1);
    check("R6 track", 32'(xfer_track), 37);
    check("R6 head", 32'(xfer_head), 1);
    check("R6 sector", 32'(xfer_sector), 13);
    check("R2 start addr", 32'(xfer_mem_addr), 32'h10400);
    check("R6 words", 32'(xfer_words), 32'hFF00);
    @(negedge clk);
    check("R6 start pulse", 32'(xfer_start), 0);
    @(negedge clk); xfer_done = 1'b1; xfer_end_addr = 18'h20010;
    @(negedge clk); xfer_done = 1'b0;
    expect_irq_after_done("R7 read", 1'b1);
    rd_chk("R2 end addr low", 3'd2, 16'h0010);
    rd_chk("R2 end addr ext", 3'd0, 16'h00EC);
  endtask

  task automatic t_read_nohdr();
    wr(3'd4, 16'h0005);
    wr(3'd0, 16'h000E);
    check("R6 fn7 start", 32'(xfer_start), 1);
    check("R6 fn7 no hdr", 32'(xfer_hdr_check), 0);
    check("R6 fn7 sector", 32'(xfer_sector), 5);
    @(negedge clk); xfer_done = 1'b1; xfer_end_addr = 18'h00200;
    @(negedge clk); xfer_done = 1'b0;
    expect_irq_after_done("R7 read no enable", 1'b0);
  endtask

  task automatic t_nop();
    int h;
    int starts;
    starts = 0;
    bus_wr = 1'b0;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h004A;
    @(negedge clk); bus_wr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (seek_start || xfer_start) starts++;
      @(negedge clk);
    end
    check("R10 nothing started", 32'(starts), 0);
    count_irq(3, h);
    check("R10 no irq", 32'(h), 0);
    rd_chk("R10 still ready", 3'd0, 16'h00CA);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_regs();
    t_addr();
    t_status();
    t_seek_ie();
    t_seek_clamp();
    t_read_hdr();
    t_read_nohdr();
    t_nop();
    do_reset();
    @(negedge clk);
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule